// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a small synchronous static memory with a 32-bit data path organised as four byte lanes. An access starts on a rising clock edge when one of two address strobes is sampled: the processor-side strobe always begins a read, while the controller-side strobe begins a read or a write according to the write controls. The low two address bits of the starting address go into an internal two-bit burst counter. On each later edge where the advance input is high, the counter steps and the next word of the four-word group is read or written. While advance is low, the counter holds and the same word is accessed again.

Reads are pipelined through an output register, so data appears on the bus one edge after the edge that registered the address. The bidirectional bus is modelled as separate input data, output data and output-enable signals. The drive enable follows the asynchronous output-enable input, but it is forced off after any write cycle and while the block sleeps. A sleep input stops all accesses. After sleep is released, the block ignores both strobes for a fixed recovery window.

Top module: `syncBurstSram`

## Requirements
- R1: After reset, no burst is active and `dOutEn` is 0 even with `outEn` high.
- R2: The block is selected only when `chipEnMain`, `chipEnAux` and `chipEnAlt` are all 1. A strobe sampled while any of them is 0 performs no access and ends any running burst.
- R3: `cpuStrobe` is ignored while `chipEnMain` is 0. A running burst then continues as if no strobe had been seen.
- R4: When both strobes are sampled together, `cpuStrobe` wins. A cycle it starts is a read even if write controls are asserted.
- R5: A `ctlStrobe` start, or a burst continuation, is a write when `globalWr` is 1 or when `byteWrEn` is 1 with at least one `laneEn` bit set; otherwise it is a read. Write data on `dIn` is taken at the same edge as the command.
- R6: `globalWr` writes all four lanes. Otherwise lane k (bits 8k+7..8k) is written only when `byteWrEn` and `laneEn[k]` are both 1, and every other lane keeps its stored value.
- R7: Read data for an address registered at edge N is driven on `dOut`, with `dOutEn` high, after edge N+1 and not before.
- R8: With `interleave` at 0, the low address bits of burst step k are (start + k) mod 4. The upper address bits stay fixed.
- R9: With `interleave` at 1, the low address bits of burst step k are start XOR k.
- R10: While `advance` is 0 during a burst, the counter holds and the same word is accessed again.
- R11: `dOutEn` equals `outEn` combinationally while read data is valid. No clock edge is needed for a change of `outEn` to take effect.
- R12: After an edge that performs a write, `dOutEn` is 0 regardless of `outEn`, even when a read result is in the output register.
- R13: While sleeping, no access is performed and `dOutEn` is 0. At the edge where `sleep` is first seen low, and at the following REC_CYCLES (default 2) edges, both strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| cpuStrobe | input | 1 | Processor-side address strobe (read start) |
| ctlStrobe | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step the burst counter |
| chipEnMain | input | 1 | Primary chip enable, also gates `cpuStrobe` |
| chipEnAux | input | 1 | Second chip enable |
| chipEnAlt | input | 1 | Third chip enable |
| globalWr | input | 1 | Write all lanes |
| byteWrEn | input | 1 | Enable per-lane writes |
| laneEn | input | 4 | Per-lane write selects |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Sleep request |
| outEn | input | 1 | Asynchronous output enable |
| dIn | input | 32 | Write data |
| dOut | output | 32 | Read data from the output register |
| dOutEn | output | 1 | Drive enable for `dOut` |

## Verification
The hardest cases to reach are those where two pipeline stages disagree. One is a read result sitting in the output register while the next edge performs a write. Another is a processor strobe arriving while the primary enable is low and a burst is running. The bench reaches the first by starting a suspended read and then holding `globalWr` on the continuation edge, with no new strobe. It reaches the second by issuing the gated strobe in the middle of an advancing burst and checking that the next word still appears. The recovery window after sleep is probed by holding a write strobe across release and then reading the target word back.

// File: rtl/sramPkg.sv
package sramPkg;
  localparam int LANE_CNT = 4;
  localparam int LANE_W   = 8;
  localparam int BURST_W  = 2;

  // Per-edge command from control to datapath
  typedef struct packed {
    logic                rdEn;
    logic                wrEn;
    logic [LANE_CNT-1:0] laneWr;
    logic                quiet;
  } sramStrobeT;
endpackage

// File: rtl/sramBurstCounter.sv
module sramBurstCounter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             interleave,
  input  logic [CNT_W-1:0] startBits,
  output logic [CNT_W-1:0] curLow,
  output logic [CNT_W-1:0] stepLow
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] startQ;

  function automatic logic [CNT_W-1:0] mapLow(input logic [CNT_W-1:0] s,
                                              input logic [CNT_W-1:0] k,
                                              input logic il);
    return il ? (s ^ k) : (s + k);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ   <= '0;
      startQ <= '0;
    end else if (load) begin
      cntQ   <= '0;
      startQ <= startBits;
    end else if (step) begin
      cntQ   <= cntQ + 1'b1;
    end
  end

  always_comb begin
    curLow  = mapLow(startQ, cntQ, interleave);
    stepLow = mapLow(startQ, cntQ + 1'b1, interleave);
  end

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !interleave) ##1 !interleave |-> curLow == CNT_W'($past(curLow) + 1'b1)); // R8
endmodule

// File: rtl/sramBurstCtrl.sv
module sramBurstCtrl import sramPkg::*; #(
  parameter int ADDR_W     = 6,
  parameter int REC_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                cpuStrobe,
  input  logic                ctlStrobe,
  input  logic                advance,
  input  logic                chipEnMain,
  input  logic                chipEnAux,
  input  logic                chipEnAlt,
  input  logic                globalWr,
  input  logic                byteWrEn,
  input  logic [LANE_CNT-1:0] laneEn,
  input  logic                interleave,
  input  logic                sleep,
  output sramStrobeT          strb,
  output logic [ADDR_W-1:0]   accAddr
);
  localparam int REC_W = $clog2(REC_CYCLES + 1);
  localparam int HI_W  = ADDR_W - BURST_W;

  logic              sleepQ;
  logic [REC_W-1:0]  recCntQ;
  logic              burstActQ;
  logic [HI_W-1:0]   baseQ;

  logic blocked, allSel, cpuGo, ctlGo, startAcc, deselect, contAcc;
  logic wrCmd, accWrite, accRead;
  logic [LANE_CNT-1:0] laneMask;
  logic [BURST_W-1:0]  curLow, stepLow;

  always_comb begin
    blocked  = sleep | sleepQ | (recCntQ != '0);
    allSel   = chipEnMain & chipEnAux & chipEnAlt;
    cpuGo    = ~blocked & cpuStrobe & chipEnMain;
    ctlGo    = ~blocked & ~cpuGo & ctlStrobe;
    startAcc = (cpuGo | ctlGo) & allSel;
    deselect = (cpuGo | ctlGo) & ~allSel;
    contAcc  = ~blocked & ~cpuGo & ~ctlGo & burstActQ;
    wrCmd    = globalWr | (byteWrEn & (|laneEn));
    laneMask = globalWr ? '1 : (byteWrEn ? laneEn : '0);
    accWrite = ((ctlGo & allSel) | contAcc) & wrCmd;
    accRead  = (cpuGo & allSel) | (((ctlGo & allSel) | contAcc) & ~wrCmd);
    strb.rdEn   = accRead;
    strb.wrEn   = accWrite;
    strb.laneWr = accWrite ? laneMask : '0;
    strb.quiet  = sleepQ;
    accAddr = startAcc ? addr : {baseQ, (advance ? stepLow : curLow)};
  end

  sramBurstCounter #(.CNT_W(BURST_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (startAcc),
    .step       (contAcc & advance),
    .interleave (interleave),
    .startBits  (addr[BURST_W-1:0]),
    .curLow     (curLow),
    .stepLow    (stepLow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleepQ    <= 1'b0;
      recCntQ   <= '0;
      burstActQ <= 1'b0;
      baseQ     <= '0;
    end else begin
      sleepQ <= sleep;
      if (sleepQ && !sleep)   recCntQ <= REC_W'(REC_CYCLES);
      else if (recCntQ != '0) recCntQ <= recCntQ - 1'b1;

      if (sleep)         burstActQ <= 1'b0;
      else if (startAcc) burstActQ <= 1'b1;
      else if (deselect) burstActQ <= 1'b0;

      if (startAcc) baseQ <= addr[ADDR_W-1:BURST_W];
    end
  end

  AST_CPU_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuStrobe && chipEnMain && !blocked) |-> !strb.wrEn); // R4
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuStrobe && !chipEnMain && !ctlStrobe && !burstActQ) |-> !(strb.rdEn || strb.wrEn)); // R3
  AST_RECOVERY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleepQ) |=> !(strb.rdEn || strb.wrEn)); // R13
endmodule

// File: rtl/sramDatapath.sv
module sramDatapath import sramPkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  sramStrobeT                   strb,
  input  logic [ADDR_W-1:0]            accAddr,
  input  logic [LANE_CNT*LANE_W-1:0]   dIn,
  input  logic                         outEn,
  output logic [LANE_CNT*LANE_W-1:0]   dOut,
  output logic                         dOutEn
);
  localparam int DATA_W = LANE_CNT * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] memQ [DEPTH];
  logic [ADDR_W-1:0] accAddrQ;
  logic              accRdQ, wrQ, outValidQ;
  logic [DATA_W-1:0] outRegQ;

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int l = 0; l < LANE_CNT; l++) begin
        if (strb.laneWr[l]) memQ[accAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accRdQ    <= 1'b0;
      wrQ       <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      accRdQ    <= strb.rdEn;
      wrQ       <= strb.wrEn;
      outValidQ <= accRdQ & ~strb.quiet;
    end
  end

  always_ff @(posedge clk) begin
    accAddrQ <= accAddr;
    if (accRdQ) outRegQ <= memQ[accAddrQ];
  end

  assign dOut   = outRegQ;
  assign dOutEn = outEn & outValidQ & ~wrQ & ~strb.quiet;

  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrEn |=> !dOutEn); // R12
  AST_WAKE_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb.quiet) |-> !dOutEn); // R13
  AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdEn ##1 !strb.quiet) |=> outValidQ); // R7
endmodule

// File: rtl/syncBurstSram.sv
module syncBurstSram #(
  parameter int ADDR_W     = 6,
  parameter int REC_CYCLES = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic [ADDR_W-1:0]                            addr,
  input  logic                                         cpuStrobe,
  input  logic                                         ctlStrobe,
  input  logic                                         advance,
  input  logic                                         chipEnMain,
  input  logic                                         chipEnAux,
  input  logic                                         chipEnAlt,
  input  logic                                         globalWr,
  input  logic                                         byteWrEn,
  input  logic [sramPkg::LANE_CNT-1:0]                 laneEn,
  input  logic                                         interleave,
  input  logic                                         sleep,
  input  logic                                         outEn,
  input  logic [sramPkg::LANE_CNT*sramPkg::LANE_W-1:0] dIn,
  output logic [sramPkg::LANE_CNT*sramPkg::LANE_W-1:0] dOut,
  output logic                                         dOutEn
);
  sramPkg::sramStrobeT strb;
  logic [ADDR_W-1:0]   accAddr;

  sramBurstCtrl #(.ADDR_W(ADDR_W), .REC_CYCLES(REC_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .cpuStrobe(cpuStrobe), .ctlStrobe(ctlStrobe), .advance(advance),
    .chipEnMain(chipEnMain), .chipEnAux(chipEnAux), .chipEnAlt(chipEnAlt),
    .globalWr(globalWr), .byteWrEn(byteWrEn), .laneEn(laneEn),
    .interleave(interleave), .sleep(sleep),
    .strb(strb), .accAddr(accAddr)
  );

  sramDatapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .accAddr(accAddr),
    .dIn(dIn), .outEn(outEn), .dOut(dOut), .dOutEn(dOutEn)
  );
endmodule

// File: tb/syncBurstSram_tb.sv
module syncBurstSram_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] addr;
  logic cpuStrobe, ctlStrobe, advance, ceMain, ceAux, ceAlt;
  logic globalWr, byteWrEn, interleave, sleep, outEn;
  logic [3:0] laneEn;
  logic [31:0] dIn, dOut;
  logic dOutEn;
  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  syncBurstSram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpuStrobe(cpuStrobe), .ctlStrobe(ctlStrobe),
    .advance(advance), .chipEnMain(ceMain), .chipEnAux(ceAux), .chipEnAlt(ceAlt),
    .globalWr(globalWr), .byteWrEn(byteWrEn), .laneEn(laneEn), .interleave(interleave),
    .sleep(sleep), .outEn(outEn), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  // {isWrite, addr, lanes (F = global write), data or expected}
  localparam logic [42:0] VEC [14] = '{
    {1'b1, 6'd5,  4'hF, 32'hA1B2C3D4}, {1'b0, 6'd5,  4'h0, 32'hA1B2C3D4},
    {1'b1, 6'd5,  4'h5, 32'h11223344}, {1'b0, 6'd5,  4'h0, 32'hA122C344},
    {1'b1, 6'd9,  4'hF, 32'h00000000}, {1'b1, 6'd9,  4'hA, 32'hDEADBEEF},
    {1'b0, 6'd9,  4'h0, 32'hDE00BE00}, {1'b1, 6'd16, 4'hF, 32'h10101010},
    {1'b1, 6'd17, 4'hF, 32'h17171717}, {1'b1, 6'd18, 4'hF, 32'h18181818},
    {1'b1, 6'd19, 4'hF, 32'h19191919}, {1'b1, 6'd20, 4'hF, 32'h13579BDF},
    {1'b0, 6'd20, 4'h0, 32'h13579BDF}, {1'b0, 6'd16, 4'h0, 32'h10101010}
  };

  function automatic logic [31:0] groupVal(input logic [1:0] low);
    case (low)
      2'd0: return 32'h10101010;
      2'd1: return 32'h17171717;
      2'd2: return 32'h18181818;
      default: return 32'h19191919;
    endcase
  endfunction

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic idle;
    cpuStrobe = 0; ctlStrobe = 0; advance = 0; globalWr = 0; byteWrEn = 0;
    laneEn = 0; ceMain = 1; ceAux = 1; ceAlt = 1;
  endtask

  task automatic deselect;
    idle; ctlStrobe = 1; ceAux = 0;
  endtask

  task automatic checkOut(input string req, input logic [31:0] exp);
    nChecks++;
    if (dOutEn !== 1'b1 || dOut !== exp) begin
      nFail++;
      $display("FAIL %s: actual en=%b data=%h expected en=1 data=%h", req, dOutEn, dOut, exp);
    end
  endtask

  task automatic checkOff(input string req);
    nChecks++;
    if (dOutEn !== 1'b0) begin
      nFail++;
      $display("FAIL %s: actual en=%b expected en=0", req, dOutEn);
    end
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [3:0] lanes, input logic [31:0] d);
    idle; addr = a; ctlStrobe = 1; dIn = d;
    if (lanes == 4'hF) globalWr = 1; else begin byteWrEn = 1; laneEn = lanes; end
    tick; deselect; tick; idle;
  endtask

  task automatic doRead(input logic [5:0] a, input logic [31:0] exp, input string req);
    idle; addr = a; cpuStrobe = 1; tick; deselect; tick; checkOut(req, exp); idle;
  endtask

  task automatic burst4(input logic [1:0] start, input logic il, input string req);
    idle; interleave = il; addr = {4'd4, start}; cpuStrobe = 1; tick;
    cpuStrobe = 0; advance = 1;
    for (int k = 0; k < 4; k++) begin
      if (k == 3) deselect;
      tick;
      checkOut(req, groupVal(il ? (start ^ 2'(k)) : (start + 2'(k))));
    end
    idle; interleave = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    idle; addr = 0; dIn = 0; interleave = 0; sleep = 0; outEn = 1;
    tick; tick; tick; rst_n = 1; tick;
    checkOff("R1 reset");

    for (int i = 0; i < 14; i++) begin
      automatic logic [42:0] v = VEC[i];
      if (v[42]) doWrite(v[41:36], v[35:32], v[31:0]);
      else doRead(v[41:36], v[31:0], "R5/R6 table");
    end

    // R7 latency, then R11 async enable, then R12 write mutes output
    idle; addr = 6'd20; cpuStrobe = 1; tick;
    checkOff("R7 first edge");
    cpuStrobe = 0; advance = 0; tick;
    checkOut("R7 second edge", 32'h13579BDF);
    outEn = 0; #1 checkOff("R11 outEn low");
    outEn = 1; #1 checkOut("R11 outEn high", 32'h13579BDF);
    globalWr = 1; dIn = 32'h00000055; tick;
    checkOff("R12 write after read");
    deselect; tick; idle;
    doRead(6'd20, 32'h00000055, "R12 continuation write");

    burst4(2'd2, 1'b0, "R8 linear");
    burst4(2'd1, 1'b1, "R9 interleaved");

    // R10 suspend
    idle; addr = 6'd16; cpuStrobe = 1; tick;
    cpuStrobe = 0; advance = 0; tick; checkOut("R10 hold a", 32'h10101010);
    advance = 1; tick; checkOut("R10 hold b", 32'h10101010);
    deselect; tick; checkOut("R10 resume", 32'h17171717); idle;

    // R3 gated processor strobe mid-burst
    idle; addr = 6'd16; cpuStrobe = 1; tick;
    advance = 1; ceMain = 0; addr = 6'd5; tick; checkOut("R3 gated a", 32'h10101010);
    cpuStrobe = 0; ceMain = 1; tick; checkOut("R3 gated b", 32'h17171717);
    deselect; tick; idle;

    // R4 both strobes, write controls ignored
    idle; addr = 6'd5; cpuStrobe = 1; ctlStrobe = 1; globalWr = 1; dIn = 32'hFFFFFFFF; tick;
    deselect; tick; checkOut("R4 read wins", 32'hA122C344); idle;
    doRead(6'd5, 32'hA122C344, "R4 no write");

    // R2 partial select
    idle; addr = 6'd5; ctlStrobe = 1; ceAlt = 0; globalWr = 1; dIn = 32'h0; tick; idle; tick;
    doRead(6'd5, 32'hA122C344, "R2 unselected write");
    idle; addr = 6'd20; cpuStrobe = 1; ceAux = 0; tick; idle; tick;
    checkOff("R2 unselected read");

    // R13 sleep and recovery
    idle; sleep = 1; tick; tick; checkOff("R13 sleeping");
    addr = 6'd5; ctlStrobe = 1; globalWr = 1; dIn = 32'h0; tick;
    sleep = 0; tick; tick; tick;
    checkOff("R13 recovery");
    doRead(6'd5, 32'hA122C344, "R13 strobes ignored");

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule